// File: doc/BRIEF.md
# Variable-Length SPI Slave Character Engine

This block is the receive/transmit core of an SPI slave port. An external master drives a serial clock, an active-low select and a data line into the block. The block returns one bit per clock on its output data line. Characters can be from 1 to 8 bits long, and software chooses the length. When a character completes, the block latches what it received, reloads its shift register from the transmit holding register and, if enabled, raises an interrupt. Consecutive characters can stream under a single select.

When the master drops select part-way through a character, the block records an abort and raises an interrupt. The next selection then restarts from the top transmit bit, wherever the broken character had stopped. Software can also raise the interrupt on its own through a control strobe. It uses this to start the first load of the transmit data.

Software reaches the block through a small register port. It has four word addresses:

- 0: data. A write fills the transmit holding register. A read returns the last received character.
- 1: mode. Bits [2:0] hold the character length.
- 2: control. Bit 0 is the interrupt enable. Bit 1 is the force strobe, which reads back as 0.
- 3: status. Bit 0 is the pending interrupt and bit 1 is the abort flag. Both are write-1-to-clear.

Top module: `spi_char_slave`

## Requirements
- R1: After reset, all four registers read 0, `irq_o` is 0 and `miso_o` is 0.
- R2: With length field 0, a character is 8 bits long. `miso_o` presents transmit bits 7 down to 0, one per SCK cycle, and the received bits are shifted in MSB first.
- R3: With length field N (1..7), a character ends after N rising SCK edges. The data register then reads {transmit bits [7-N:0], received N bits}, with the first received bit in position N-1.
- R4: When bit 0 of control is 1, completing a character sets status bit 0 and `irq_o`. When that enable bit is 0, a completed character leaves both at 0.
- R5: Characters can follow each other without select being released. Each one raises its own interrupt. The character after a completion transmits the holding register as it stood when the previous character completed.
- R6: If select is released after at least one bit but before the last bit, status bit 1 is set and an interrupt is raised when enabled. The data register is left unchanged.
- R7: On every assertion of select, including the first one after an abort, `miso_o` presents bit 7 of the transmit holding register before the first SCK edge.
- R8: Writing 1 to status bit 1 clears the abort flag. Writing 0 leaves it set.
- R9: Once set, the interrupt stays pending until a 1 is written to status bit 0. No other event clears it.
- R10: Writing 1 to control bit 1 sets the pending interrupt in the next cycle, whether or not the enable bit is set.
- R11: SPI mode 0 applies. MOSI is sampled on rising SCK, and `miso_o` changes only after a falling SCK or a select assertion, once the two-flop synchronizers have passed the edge. While deselected, `miso_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Pending interrupt request |

## Verification
The checker assumes that SCK, select and MOSI change slowly compared with the system clock. Each level must last several system cycles, so that the synchronizers never drop or merge an edge. It also assumes that the length field is only rewritten while select is released, which keeps the bit counter below the character length. The bench holds every SCK and select phase for eight system clocks, changes MOSI only while SCK is low, and writes the mode register only between selections.

// File: rtl/spi_slv_pkg.sv
`timescale 1ns/1ps
package spi_slv_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_MODE = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_IE_BIT  = 0;
  localparam int unsigned CTRL_GO_BIT  = 1;
  localparam int unsigned STAT_IRQ_BIT = 0;
  localparam int unsigned STAT_ABT_BIT = 1;

  typedef struct packed {
    logic done;
    logic abort;
  } shift_evt_t;
endpackage

// File: rtl/spi_slv_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a bundle of slow asynchronous inputs.
module spi_slv_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_n;

  always_comb begin
    stg_n = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RESET_VAL}};
    else        stg_q <= stg_n;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_slv_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release.
module spi_slv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/spi_slv_shifter.sv
`timescale 1ns/1ps
// Serial shift engine: edge detection, bit counting, abort detection.
module spi_slv_shifter
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = $clog2(DATA_W),
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              ss_n_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  char_len,
  output logic              miso,
  output logic [DATA_W-1:0] rx_data,
  output shift_evt_t        evt,
  output logic              sel,
  output logic              sck_fall,
  output logic              ss_fall,
  output logic              ss_rise,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic              sck_q, ss_q;
  logic              sck_rise;
  logic [DATA_W-1:0] shift_q, shift_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              miso_q, miso_n;
  logic [CNT_W-1:0]  len_eff;
  logic              last_bit;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign sel      = ~ss_n_s;
  assign ss_fall  = ~ss_n_s & ss_q;
  assign ss_rise  = ss_n_s & ~ss_q;

  assign len_eff  = (char_len == '0) ? CNT_W'(DATA_W) : CNT_W'(char_len);
  assign last_bit = (cnt_q == (len_eff - CNT_W'(1)));
  assign rx_data  = {shift_q[DATA_W-2:0], mosi_s};

  always_comb begin
    shift_n   = shift_q;
    cnt_n     = cnt_q;
    miso_n    = miso_q;
    evt.done  = 1'b0;
    evt.abort = 1'b0;
    if (ss_fall) begin
      shift_n = tx_data;
      cnt_n   = '0;
      miso_n  = tx_data[DATA_W-1];
    end else if (ss_rise) begin
      cnt_n     = '0;
      evt.abort = (cnt_q != '0);
    end else if (sel) begin
      if (sck_rise) begin
        if (last_bit) begin
          evt.done = 1'b1;
          shift_n  = tx_data;
          cnt_n    = '0;
        end else begin
          shift_n = {shift_q[DATA_W-2:0], mosi_s};
          cnt_n   = cnt_q + CNT_W'(1);
        end
      end else if (sck_fall) begin
        miso_n = shift_q[DATA_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      ss_q    <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
      miso_q  <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      ss_q    <= ss_n_s;
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
      miso_q  <= miso_n;
    end
  end

  assign miso    = sel & miso_q;
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/spi_slv_regs.sv
`timescale 1ns/1ps
// Register file: transmit holding, receive latch, mode, control, status.
module spi_slv_regs
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  shift_evt_t        evt,
  input  logic [DATA_W-1:0] rx_in,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] tx_data,
  output logic [LEN_W-1:0]  char_len,
  output logic              irq,
  output logic              abort_flag
);
  logic [DATA_W-1:0] tx_q, tx_n, rx_q, rx_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic              ie_q, ie_n, irq_q, irq_n, abt_q, abt_n;
  logic              wr_data, wr_mode, wr_ctrl, wr_stat;
  logic              force_irq, irq_set, irq_clr, abt_clr;
  reg_addr_e         addr_e;

  assign addr_e  = reg_addr_e'(addr);
  assign wr_data = wr && (addr_e == REG_DATA);
  assign wr_mode = wr && (addr_e == REG_MODE);
  assign wr_ctrl = wr && (addr_e == REG_CTRL);
  assign wr_stat = wr && (addr_e == REG_STAT);

  assign force_irq = wr_ctrl && wdata[CTRL_GO_BIT];
  assign irq_clr   = wr_stat && wdata[STAT_IRQ_BIT];
  assign abt_clr   = wr_stat && wdata[STAT_ABT_BIT];
  assign irq_set   = ((evt.done || evt.abort) && ie_q) || force_irq;

  always_comb begin
    tx_n  = wr_data ? wdata : tx_q;
    rx_n  = evt.done ? rx_in : rx_q;
    len_n = wr_mode ? wdata[LEN_W-1:0] : len_q;
    ie_n  = wr_ctrl ? wdata[CTRL_IE_BIT] : ie_q;
    irq_n = irq_set | (irq_q & ~irq_clr);
    abt_n = evt.abort | (abt_q & ~abt_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      len_q <= '0;
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
      abt_q <= 1'b0;
    end else begin
      tx_q  <= tx_n;
      rx_q  <= rx_n;
      len_q <= len_n;
      ie_q  <= ie_n;
      irq_q <= irq_n;
      abt_q <= abt_n;
    end
  end

  always_comb begin
    unique case (addr_e)
      REG_DATA: rdata = rx_q;
      REG_MODE: rdata = {{(DATA_W-LEN_W){1'b0}}, len_q};
      REG_CTRL: rdata = {{(DATA_W-1){1'b0}}, ie_q};
      REG_STAT: rdata = {{(DATA_W-2){1'b0}}, abt_q, irq_q};
      default:  rdata = '0;
    endcase
  end

  assign tx_data    = tx_q;
  assign char_len   = len_q;
  assign irq        = irq_q;
  assign abort_flag = abt_q;
endmodule

// File: rtl/spi_char_slave.sv
`timescale 1ns/1ps
// Top: SPI slave with variable character length and abort detection.
module spi_char_slave
  import spi_slv_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LEN_W      = $clog2(DATA_W),
  localparam int unsigned CNT_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic              rst_sync_n;
  logic [2:0]        pins_s;
  logic              sck_s, ss_n_s, mosi_s;
  logic [DATA_W-1:0] tx_data, rx_data;
  logic [LEN_W-1:0]  char_len;
  shift_evt_t        evt;
  logic              sel, sck_fall, ss_fall, ss_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic              abort_flag;

  spi_slv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  spi_slv_sync #(
    .WIDTH     (3),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({sck_i, ss_n_i, mosi_i}),
    .q     (pins_s)
  );
  assign {sck_s, ss_n_s, mosi_s} = pins_s;

  spi_slv_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sck_s    (sck_s),
    .ss_n_s   (ss_n_s),
    .mosi_s   (mosi_s),
    .tx_data  (tx_data),
    .char_len (char_len),
    .miso     (miso_o),
    .rx_data  (rx_data),
    .evt      (evt),
    .sel      (sel),
    .sck_fall (sck_fall),
    .ss_fall  (ss_fall),
    .ss_rise  (ss_rise),
    .bit_cnt  (bit_cnt)
  );

  spi_slv_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr         (reg_wr_i),
    .addr       (reg_addr_i),
    .wdata      (reg_wdata_i),
    .evt        (evt),
    .rx_in      (rx_data),
    .rdata      (reg_rdata_o),
    .tx_data    (tx_data),
    .char_len   (char_len),
    .irq        (irq_o),
    .abort_flag (abort_flag)
  );
endmodule

// File: rtl/spi_char_slave_chk.sv
`timescale 1ns/1ps
module spi_char_slave_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic              abort_flag,
  input logic              miso,
  input logic              sel,
  input logic              sck_fall,
  input logic              ss_fall,
  input logic              ss_rise,
  input logic [CNT_W-1:0]  bit_cnt
);
  // R6
  abort_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_rise && bit_cnt != '0) |=> abort_flag);

  // R8
  abort_clear_only_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(abort_flag) |-> $past(reg_wr && reg_addr == 2'd3 && reg_wdata[1]));

  // R9
  irq_clear_only_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr && reg_addr == 2'd3 && reg_wdata[0]));

  // R10
  force_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && reg_wdata[1]) |=> irq);

  // R11
  miso_holds_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel) && !$past(sck_fall) && !$past(ss_fall)) |-> $stable(miso));

  // R11
  miso_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !miso);

  // R3
  bit_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(DATA_W));
endmodule

bind spi_char_slave spi_char_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_wr     (reg_wr_i),
  .reg_addr   (reg_addr_i),
  .reg_wdata  (reg_wdata_i),
  .irq        (irq_o),
  .abort_flag (abort_flag),
  .miso       (miso_o),
  .sel        (sel),
  .sck_fall   (sck_fall),
  .ss_fall    (ss_fall),
  .ss_rise    (ss_rise),
  .bit_cnt    (bit_cnt)
);

// File: tb/tb_spi_char_slave.sv
`timescale 1ns/1ps
module tb_spi_char_slave;
  localparam int HP = 8;

  logic       clk, rst_n, sck, ss_n, mosi, miso, wr, irq;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    string      req;
    logic [7:0] val;
  } item_t;
  item_t      exp_q[$];
  logic [7:0] obs_q[$];

  spi_char_slave dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi),
    .miso_o(miso), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pairs observed results with expected items.
  initial begin
    forever begin
      @(negedge clk);
      if (obs_q.size() > 0 && exp_q.size() > 0) begin
        item_t      e;
        logic [7:0] o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        chk(e.req, o, e.val);
      end
    end
  end

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
    wclk(2);
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic select();
    ss_n = 0;
    wclk(HP);
  endtask

  task automatic deselect();
    ss_n = 1;
    wclk(HP);
  endtask

  // One character, MSB of mosi_val first; returns the MISO bits seen.
  task automatic spi_char(int nbits, logic [7:0] mosi_val, output logic [7:0] seen);
    seen = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = mosi_val[nbits-1-i];
      wclk(HP);
      seen[nbits-1-i] = miso;
      sck = 1;
      wclk(HP);
      sck = 0;
    end
    wclk(HP);
  endtask

  task automatic expect_item(string req, logic [7:0] v);
    item_t it;
    it.req = req;
    it.val = v;
    exp_q.push_back(it);
  endtask

  task automatic xfer(string req, int nbits, logic [7:0] mosi_val, logic [7:0] exp_miso,
                      logic [7:0] exp_rx);
    logic [7:0] seen, rd;
    expect_item({req, " miso"}, exp_miso);
    expect_item({req, " rx"}, exp_rx);
    spi_char(nbits, mosi_val, seen);
    obs_q.push_back(seen);
    reg_read(2'd0, rd);
    obs_q.push_back(rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, seen;
    rst_n = 0; sck = 0; ss_n = 1; mosi = 0; wr = 0; addr = 0; wdata = 0;
    wclk(4);
    rst_n = 1;
    wclk(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), rd);
      chk("R1 reg", rd, 8'h00);
    end
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 miso", {7'd0, miso}, 8'h00);

    // R2, R4: 8-bit character, interrupt enabled
    reg_write(2'd1, 8'h00);
    reg_write(2'd2, 8'h01);
    reg_write(2'd0, 8'hA5);
    select();
    chk("R7 first bit", {7'd0, miso}, 8'h01);
    xfer("R2", 8, 8'h3C, 8'hA5, 8'h3C);
    chk("R4 irq set", {7'd0, irq}, 8'h01);
    wclk(20);
    chk("R9 irq held", {7'd0, irq}, 8'h01);
    reg_write(2'd3, 8'h01);
    chk("R9 irq cleared", {7'd0, irq}, 8'h00);

    // R5: back-to-back under same select; reload happened at completion (0xA5)
    reg_write(2'd0, 8'h5A);
    xfer("R5", 8, 8'hC3, 8'hA5, 8'hC3);
    chk("R5 irq again", {7'd0, irq}, 8'h01);
    reg_write(2'd3, 8'h01);
    deselect();
    reg_read(2'd3, rd);
    chk("R6 no abort at boundary", rd, 8'h00);

    // R3: 3-bit characters, tx 0x5A
    reg_write(2'd1, 8'h03);
    select();
    xfer("R3 len3", 3, 8'h05, 8'h02, 8'hD5);
    chk("R3 irq", {7'd0, irq}, 8'h01);
    reg_write(2'd3, 8'h01);
    deselect();

    // R3: 1-bit character
    reg_write(2'd1, 8'h01);
    reg_write(2'd0, 8'h80);
    select();
    xfer("R3 len1", 1, 8'h00, 8'h01, 8'h00);
    reg_write(2'd3, 8'h01);
    deselect();

    // R4: interrupt disabled
    reg_write(2'd2, 8'h00);
    reg_write(2'd1, 8'h00);
    select();
    xfer("R4 no-ie", 8, 8'h11, 8'h80, 8'h11);
    deselect();
    reg_read(2'd3, rd);
    chk("R4 status without enable", rd, 8'h00);
    chk("R4 irq without enable", {7'd0, irq}, 8'h00);

    // R6: abort after 3 of 8 bits
    reg_write(2'd2, 8'h01);
    reg_write(2'd0, 8'hC6);
    select();
    spi_char(3, 8'h07, seen);
    deselect();
    reg_read(2'd3, rd);
    chk("R6 abort status", rd, 8'h03);
    chk("R6 irq", {7'd0, irq}, 8'h01);
    reg_read(2'd0, rd);
    chk("R6 data unchanged", rd, 8'h11);

    // R8: write-1-to-clear of the abort flag
    reg_write(2'd3, 8'h00);
    reg_read(2'd3, rd);
    chk("R8 write 0 keeps", rd, 8'h03);
    reg_write(2'd3, 8'h02);
    reg_read(2'd3, rd);
    chk("R8 abort cleared", rd, 8'h01);
    reg_write(2'd3, 8'h01);

    // R7: restart from bit 7 after abort
    select();
    chk("R7 bit7 after abort", {7'd0, miso}, 8'h01);
    xfer("R7", 8, 8'hFF, 8'hC6, 8'hFF);
    reg_write(2'd3, 8'h01);
    deselect();

    // R10: forced interrupt, with and without enable
    reg_write(2'd2, 8'h03);
    chk("R10 forced irq", {7'd0, irq}, 8'h01);
    reg_read(2'd2, rd);
    chk("R10 strobe reads 0", rd, 8'h01);
    reg_write(2'd3, 8'h01);
    reg_write(2'd2, 8'h02);
    reg_read(2'd3, rd);
    chk("R10 forced without enable", rd, 8'h01);
    chk("R11 idle miso", {7'd0, miso}, 8'h00);

    wclk(10);
    if (exp_q.size() != 0 || obs_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule